// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block moves a clock-and-supply pair, called an operating point (a frequency ratio plus a supply voltage code), from its present value to a requested one. It does this as an ordered series of steps, so the supply is never below what the running frequency needs. When the ratio goes up, the voltage is walked to its target one code at a time and the new ratio is applied afterwards. When the ratio goes down, the new ratio is applied first and the voltage is walked down afterwards. Every ratio change waits for a lock acknowledge from the clock generator.

A request is a one-cycle `req_valid` with a target point, and it may arrive on any cycle. When the sequencer is idle, the request starts at once. While a transition is running, the request is parked in a single holding slot, and a newer request replaces the one already parked there. The parked target starts on the cycle after the running transition reports `done`. The regulator is modelled by `step_ack`, which must be high for a voltage step to take effect. The steps are spaced by a programmable number of cycles (`ramp_interval`).

Top module: `pstate_seq`

## Requirements
- R1: After reset the outputs show the reset point (ratio 8, voltage code 16), and `busy` and `done` are low.
- R2: A request taken while idle whose target differs from the current point raises `busy` on the next cycle.
- R3: A request that arrives while `busy` is high does not alter the transition in progress. That transition ends at its own target, and the parked target then starts on the cycle after `done`.
- R4: Only one parked request is kept. When several requests arrive during one transition, only the last of them is carried out afterwards.
- R5: `cur_vcode` never changes by more than one code between two consecutive cycles.
- R6: A target ratio greater than or equal to the current ratio counts as upward. In an upward move `cur_ratio` keeps its old value until `cur_vcode` has reached the target code.
- R7: In a downward move (target ratio below the current ratio) `cur_ratio` takes the target on the cycle after the request, and `cur_vcode` does not move until `lock_ack` has been seen.
- R8: While `step_ack` is low, `cur_vcode` holds its value.
- R9: `done` is never issued while a ratio change is waiting for `lock_ack`.
- R10: A request whose target equals the current point produces `done` on the next cycle, leaves `busy` low and changes no output.
- R11: `done` is a single-cycle pulse at the end of each transition, and `busy` is low whenever `done` is high.
- R12: When the ratio changes by a nonzero amount, the voltage moves by k codes, the interval I is at least 1, and both acknowledges are held high, `done` appears k*I+2 cycles after the request cycle.
- R13: A `ramp_interval` of 0 behaves exactly like an interval of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle transition request |
| req_ratio | input | 8 | Target frequency ratio |
| req_vcode | input | 6 | Target voltage code |
| ramp_interval | input | RAMP_W (8) | Cycles between voltage steps; 0 is treated as 1 |
| step_ack | input | 1 | Regulator accepts a voltage step this cycle |
| lock_ack | input | 1 | Clock generator reports lock at the new ratio |
| cur_ratio | output | 8 | Frequency ratio now applied |
| cur_vcode | output | 6 | Voltage code now applied |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle pulse at the end of a transition |

## Verification
The request is sampled at one clock edge (cycle 0). After that edge `busy` is high, or, for an equal target, `done` is high. In a downward move the new ratio is also already visible then. The bench counts falling edges from cycle 0, and the full transition is expected to end with `done` at cycle k*I+2. Every voltage step is expected I cycles after the previous one, and the ratio change one cycle after the last step. At each falling edge the bench compares `cur_ratio` and `cur_vcode` with their previous values to check the ordering, and it checks parked requests only after the `done` that comes before them.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  localparam int RATIO_W = 8;
  localparam int VCODE_W = 6;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [VCODE_W-1:0] vcode_t;

  typedef struct packed {
    ratio_t ratio;
    vcode_t vcode;
  } opp_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_VRAMP = 2'd1,
    PH_FLOCK = 2'd2
  } phase_e;

  // identical operating points need no activity
  function automatic logic opp_same(opp_t a, opp_t b);
    return (a.ratio == b.ratio) && (a.vcode == b.vcode);
  endfunction

  // an equal or higher ratio is sequenced voltage-first
  function automatic logic ratio_rises(opp_t from_p, opp_t to_p);
    return to_p.ratio >= from_p.ratio;
  endfunction

  // one code toward the target
  function automatic vcode_t vcode_toward(vcode_t cur, vcode_t tgt);
    return (tgt > cur) ? cur + vcode_t'(1) : cur - vcode_t'(1);
  endfunction
endpackage

// File: rtl/pstate_req_slot.sv
module pstate_req_slot
  import pstate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic take,
  input  opp_t d_opp,
  output logic q_valid,
  output opp_t q_opp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_opp   <= '0;
    end else if (capture) begin
      q_valid <= 1'b1;
      q_opp   <= d_opp;
    end else if (take) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pstate_ramp_timer.sv
module pstate_ramp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] interval,
  input  logic             step_ack,
  output logic             step_fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             tick;

  assign limit     = (interval == '0) ? '0 : interval - CNT_W'(1);
  assign tick      = (cnt >= limit);
  assign step_fire = run && tick && step_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || step_fire)  cnt <= '0;
    else if (!tick)              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
  import pstate_pkg::*;
#(
  parameter int RAMP_W      = 8,
  parameter int RESET_RATIO = 8,
  parameter int RESET_VCODE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [RATIO_W-1:0] req_ratio,
  input  logic [VCODE_W-1:0] req_vcode,
  input  logic [RAMP_W-1:0]  ramp_interval,
  input  logic               step_ack,
  input  logic               lock_ack,
  output logic [RATIO_W-1:0] cur_ratio,
  output logic [VCODE_W-1:0] cur_vcode,
  output logic               busy,
  output logic               done
);
  localparam opp_t RESET_OPP = '{ratio: ratio_t'(RESET_RATIO), vcode: vcode_t'(RESET_VCODE)};

  phase_e phase;
  opp_t   cur_q, tgt_q, req_opp, slot_opp, cand;
  logic   up_q, done_q, slot_v, cand_v;

  // named events for the checker
  logic   is_idle, launch, v_at_tgt, ramp_run, ramp_end, in_flock, lock_evt, step_fire;
  vcode_t tgt_vcode;

  assign req_opp   = '{ratio: req_ratio, vcode: req_vcode};
  assign is_idle   = (phase == PH_IDLE);
  assign cand_v    = req_valid || slot_v;
  assign cand      = req_valid ? req_opp : slot_opp;
  assign launch    = is_idle && cand_v;
  assign v_at_tgt  = (cur_q.vcode == tgt_q.vcode);
  assign ramp_run  = (phase == PH_VRAMP) && !v_at_tgt;
  assign ramp_end  = (phase == PH_VRAMP) && v_at_tgt;
  assign in_flock  = (phase == PH_FLOCK);
  assign lock_evt  = in_flock && lock_ack;
  assign tgt_vcode = tgt_q.vcode;

  pstate_req_slot u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (req_valid && !is_idle),
    .take    (launch),
    .d_opp   (req_opp),
    .q_valid (slot_v),
    .q_opp   (slot_opp)
  );

  pstate_ramp_timer #(.CNT_W(RAMP_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ramp_run),
    .interval  (ramp_interval),
    .step_ack  (step_ack),
    .step_fire (step_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cur_q  <= RESET_OPP;
      tgt_q  <= RESET_OPP;
      up_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (cand_v) begin
            tgt_q <= cand;
            up_q  <= ratio_rises(cur_q, cand);
            if (opp_same(cur_q, cand)) begin
              done_q <= 1'b1;
            end else if (ratio_rises(cur_q, cand)) begin
              phase <= PH_VRAMP;
            end else begin
              phase       <= PH_FLOCK;
              cur_q.ratio <= cand.ratio;
            end
          end
        end
        PH_VRAMP: begin
          if (step_fire) begin
            cur_q.vcode <= vcode_toward(cur_q.vcode, tgt_q.vcode);
          end else if (ramp_end) begin
            if (up_q && (cur_q.ratio != tgt_q.ratio)) begin
              phase       <= PH_FLOCK;
              cur_q.ratio <= tgt_q.ratio;
            end else begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        PH_FLOCK: begin
          if (lock_evt) begin
            if (up_q) begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              phase <= PH_VRAMP;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cur_ratio = cur_q.ratio;
  assign cur_vcode = cur_q.vcode;
  assign busy      = !is_idle;
  assign done      = done_q;
endmodule

// File: rtl/pstate_seq_chk.sv
module pstate_seq_chk
  import pstate_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   req_valid,
  input ratio_t req_ratio,
  input vcode_t req_vcode,
  input logic   step_ack,
  input logic   lock_ack,
  input ratio_t cur_ratio,
  input vcode_t cur_vcode,
  input logic   busy,
  input logic   done,
  input logic   up_q,
  input logic   in_flock,
  input vcode_t tgt_vcode
);
  logic req_same;
  assign req_same = (req_ratio == cur_ratio) && (req_vcode == cur_vcode);

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_same) |=> busy);

  p_vstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vcode == $past(cur_vcode)) || (cur_vcode == $past(cur_vcode) + vcode_t'(1)) ||
    (cur_vcode == $past(cur_vcode) - vcode_t'(1)));

  p_up_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && up_q && (cur_vcode != tgt_vcode)) |=> $stable(cur_ratio));

  p_down_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flock && !up_q) |=> $stable(cur_vcode));

  p_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ack |=> $stable(cur_vcode));

  p_lock_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flock && !lock_ack) |=> !done);

  p_same_point_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_same) |=> (done && !busy));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind pstate_seq pstate_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ratio (req_ratio),
  .req_vcode (req_vcode),
  .step_ack  (step_ack),
  .lock_ack  (lock_ack),
  .cur_ratio (cur_ratio),
  .cur_vcode (cur_vcode),
  .busy      (busy),
  .done      (done),
  .up_q      (up_q),
  .in_flock  (in_flock),
  .tgt_vcode (tgt_vcode)
);

// File: tb/sim_pstate_seq.sv
module sim_pstate_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_ratio = '0;
  logic [5:0] req_vcode = '0;
  logic [7:0] ramp_interval = 8'd1;
  logic       step_ack = 1'b1;
  logic       lock_ack = 1'b1;
  logic [7:0] cur_ratio;
  logic [5:0] cur_vcode;
  logic       busy, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // transition under observation
  int st_r, st_v, tg_r, tg_v, ord_err, n_edges;
  bit up_mv, done_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstate_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ratio(req_ratio),
    .req_vcode(req_vcode), .ramp_interval(ramp_interval), .step_ack(step_ack),
    .lock_ack(lock_ack), .cur_ratio(cur_ratio), .cur_vcode(cur_vcode),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive a request across one rising edge (cycle 0), return at the next falling edge
  task automatic issue(input int r, input int v);
    @(negedge clk);
    st_r = cur_ratio; st_v = cur_vcode; tg_r = r; tg_v = v;
    up_mv = (r >= st_r);
    req_valid = 1'b1; req_ratio = 8'(r); req_vcode = 6'(v);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // follow a transition from cycle 0 until done, checking step ordering
  task automatic follow(input int limit);
    int pr, pv, dv;
    pr = st_r; pv = st_v; ord_err = 0; n_edges = 0; done_seen = 0;
    forever begin
      if (cur_vcode != pv) begin
        dv = int'(cur_vcode) - pv;
        if (dv != 1 && dv != -1) ord_err++;
        if (up_mv && int'(cur_ratio) != st_r) ord_err++;
        if (!up_mv && int'(cur_ratio) != tg_r) ord_err++;
      end
      if (cur_ratio != pr) begin
        if (up_mv && int'(cur_vcode) != tg_v) ord_err++;
        if (!up_mv && int'(cur_vcode) != st_v) ord_err++;
      end
      pr = cur_ratio; pv = cur_vcode;
      if (done) begin done_seen = 1; break; end
      if (n_edges >= limit) break;
      @(negedge clk);
      n_edges++;
    end
  endtask

  task automatic t_reset();
    chk(cur_ratio == 8, "R1 ratio", cur_ratio, 8);
    chk(cur_vcode == 16, "R1 vcode", cur_vcode, 16);
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
  endtask

  task automatic t_up();
    ramp_interval = 8'd3;
    issue(12, 20);
    chk(busy, "R2 busy after request", busy, 1);
    follow(100);
    chk(n_edges == 4*3+2, "R12 up latency", n_edges, 14);
    chk(ord_err == 0, "R6 up ordering / R5 step size", ord_err, 0);
    chk(cur_ratio == 12 && cur_vcode == 20, "R6 up end point", {cur_ratio, cur_vcode}, {8'd12, 6'd20});
    @(negedge clk);
    chk(!done && !busy, "R11 done is one cycle", {done, busy}, 0);
  endtask

  task automatic t_down();
    ramp_interval = 8'd2;
    issue(6, 17);
    chk(cur_ratio == 6 && cur_vcode == 20, "R7 ratio first", {cur_ratio, cur_vcode}, {8'd6, 6'd20});
    follow(100);
    chk(n_edges == 3*2+2, "R12 down latency", n_edges, 8);
    chk(ord_err == 0, "R7 down ordering", ord_err, 0);
    chk(cur_vcode == 17, "R7 down end vcode", cur_vcode, 17);
    @(negedge clk);
  endtask

  task automatic t_same();
    issue(6, 17);
    chk(done && !busy, "R10 same point done at once", {done, busy}, 2);
    chk(cur_ratio == 6 && cur_vcode == 17, "R10 point unchanged", {cur_ratio, cur_vcode}, {8'd6, 6'd17});
    @(negedge clk);
    chk(!done, "R11 single pulse", done, 0);
  endtask

  task automatic t_izero();
    ramp_interval = 8'd0;
    issue(7, 19);
    follow(100);
    chk(n_edges == 2*1+2, "R13 interval zero as one", n_edges, 4);
    chk(ord_err == 0, "R13 ordering", ord_err, 0);
    @(negedge clk);
  endtask

  task automatic t_step_stall();
    ramp_interval = 8'd1;
    step_ack = 1'b0;
    issue(9, 21);
    repeat (5) @(negedge clk);
    chk(cur_vcode == 19 && busy, "R8 vcode held without step_ack", cur_vcode, 19);
    chk(cur_ratio == 7, "R8 ratio held during stall", cur_ratio, 7);
    step_ack = 1'b1;
    st_r = cur_ratio; st_v = cur_vcode;
    follow(100);
    chk(done_seen && cur_vcode == 21 && cur_ratio == 9, "R8 completes after ack", cur_vcode, 21);
    @(negedge clk);
  endtask

  task automatic t_lock_stall();
    bit early;
    lock_ack = 1'b0;
    early = 0;
    issue(10, 21);
    repeat (6) begin
      @(negedge clk);
      if (done) early = 1;
    end
    chk(!early && busy, "R9 no done before lock", early, 0);
    chk(cur_ratio == 10, "R9 ratio applied while waiting", cur_ratio, 10);
    lock_ack = 1'b1;
    @(negedge clk);
    chk(done, "R9 done after lock", done, 1);
    @(negedge clk);
  endtask

  task automatic t_defer();
    ramp_interval = 8'd2;
    issue(14, 25);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_ratio = 8'd9; req_vcode = 6'd20;
    @(negedge clk);
    req_valid = 1'b0;
    st_r = 10; st_v = 21;
    follow(100);
    chk(cur_ratio == 14 && cur_vcode == 25, "R3 running transition kept", {cur_ratio, cur_vcode}, {8'd14, 6'd25});
    st_r = 14; st_v = 25; tg_r = 9; tg_v = 20; up_mv = 0;
    @(negedge clk);
    chk(busy && cur_ratio == 9, "R3 parked target starts after done", {busy, cur_ratio}, {1'b1, 8'd9});
    follow(100);
    chk(n_edges == 5*2+2, "R3 R12 parked latency", n_edges, 12);
    chk(ord_err == 0 && cur_vcode == 20, "R3 parked end point", cur_vcode, 20);
    @(negedge clk);
  endtask

  task automatic t_overwrite();
    ramp_interval = 8'd1;
    issue(11, 22);
    req_valid = 1'b1; req_ratio = 8'd5; req_vcode = 6'd10;
    @(negedge clk);
    req_ratio = 8'd12; req_vcode = 6'd23;
    @(negedge clk);
    req_valid = 1'b0;
    st_r = 9; st_v = 20;
    follow(100);
    chk(cur_ratio == 11 && cur_vcode == 22, "R4 first target reached", {cur_ratio, cur_vcode}, {8'd11, 6'd22});
    st_r = 11; st_v = 22; tg_r = 12; tg_v = 23; up_mv = 1;
    @(negedge clk);
    chk(busy, "R4 parked request starts", busy, 1);
    follow(100);
    chk(n_edges == 1*1+2, "R4 latency of last request", n_edges, 3);
    chk(cur_ratio == 12 && cur_vcode == 23, "R4 last request wins", {cur_ratio, cur_vcode}, {8'd12, 6'd23});
    @(negedge clk);
    chk(!busy && !done, "R4 nothing further runs", {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_up();
    t_down();
    t_same();
    t_izero();
    t_step_stall();
    t_lock_stall();
    t_defer();
    t_overwrite();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule